// File: doc/BRIEF.md
# Four-Direction Demand-Driven Traffic Light Controller

This block runs the signals at a road crossing where each of the four travel directions has its own lamp and its own vehicle detector. The lanes are indexed 0 north-to-south, 1 south-to-north, 2 west-to-east and 3 east-to-west. Lanes 0 and 1 form the vertical axis and lanes 2 and 3 form the horizontal axis. A lamp turns green only for a direction in which a vehicle has been detected. The two directions of one axis may be green together, or one may be green alone. The two axes are never green at the same time.

Detector hits are latched until the lane is served, so a short pulse is never lost. Timing comes from cycle counters set by three parameters: the minimum green time, the yellow time and the all-red clearance time. A green phase lasts for at least its minimum. It then continues while a lit lane's detector stays high and the crossing axis has no demand. When both axes are waiting, the axis that was not served last gets the next green, so neither axis can be shut out.

Top module: `crossing_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with no demand, every lamp is red. Each lamp is a 2-bit field of `lamps_o`: lane i uses bits [2i+1:2i], with 00 red, 01 yellow and 10 green.
- R2: No lamp of lanes 0/1 is green in the same cycle as a lamp of lanes 2/3.
- R3: A lamp turns green only if its lane has demand. Demand means the detector is high at that edge, or it was high at some edge since the lamp was last green. A lane without demand stays red even while the other lane of its axis is green.
- R4: Once any lamp turns green, at least one lamp stays green for at least GREEN_MIN consecutive cycles.
- R5: A green lamp that stops being green shows yellow for exactly YELLOW_LEN cycles and then red. A red lamp never turns yellow.
- R6: After the last yellow cycle, all lamps stay red for at least CLEAR_LEN cycles before any lamp turns green.
- R7: When all lamps are red and the controller is idle, a detector hit turns that lamp green at the next cycle.
- R8: Any lane with demand sees green within 2*(GREEN_MIN+YELLOW_LEN+CLEAR_LEN)+4 cycles.
- R9: While an axis is green and its green is not ending, the other lane of that axis turns green at the next cycle when it gains demand.
- R10: A green lamp stays green while its detector stays high and the other axis has no demand.
- R11: If both axes gain demand together while the crossing is idle, the axis that was not served most recently goes green first.
- R12: A lane served by a one-cycle detector pulse, with no further demand, is green for exactly GREEN_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_i | input | 4 | Vehicle detectors, bit i for lane i |
| lamps_o | output | 8 | Lamp states, 2 bits per lane (00 red, 01 yellow, 10 green) |

## Verification
The bound checker watches the lamps every cycle. It checks axis exclusion, green only after demand, the green-to-yellow-to-red order, the exact yellow length, the minimum green run and the all-red gap, so these rules are enforced across the whole random run. Some behaviours depend on history that a simple property cannot carry, and only the bench's scenarios show them. These are the bound on waiting time, joining a green already in progress, holding green on a steady detector, the exact green length after a single pulse, and giving the first green to the axis not served last.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    LAMP_RED = 2'b00,
    LAMP_YEL = 2'b01,
    LAMP_GRN = 2'b10
  } lamp_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GO    = 2'd1,
    PH_WARN  = 2'd2,
    PH_CLEAR = 2'd3
  } phase_t;

  localparam int unsigned LANES = 4;

  // lanes belonging to an axis: 0 -> lanes 0/1, 1 -> lanes 2/3
  function automatic logic [LANES-1:0] axis_mask(input logic ax);
    return ax ? 4'b1100 : 4'b0011;
  endfunction

  // {valid, axis}: prefer the axis not served last
  function automatic logic [1:0] choose_axis(input logic [LANES-1:0] dem,
                                             input logic last);
    if (|(dem & axis_mask(!last))) return {1'b1, !last};
    if (|(dem & axis_mask(last)))  return {1'b1, last};
    return 2'b00;
  endfunction

  // true on the final cycle of a span of len cycles counted from 0
  function automatic logic span_done(input int unsigned cnt,
                                     input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tl_demand_latch.sv
module tl_demand_latch
  import tl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] sens_i,
  input  logic [LANES-1:0] served_i,
  output logic [LANES-1:0] dem_o
);
  logic [LANES-1:0] pend_q;

  assign dem_o = pend_q | sens_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= dem_o & ~served_i;
  end
endmodule

// File: rtl/tl_phase_ctrl.sv
module tl_phase_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned GREEN_MIN  = 8,
  parameter int unsigned YELLOW_LEN = 3,
  parameter int unsigned CLEAR_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] dem_i,
  input  logic [LANES-1:0] sens_i,
  output phase_t           phase_o,
  output logic [LANES-1:0] lit_o
);
  localparam int unsigned SPAN_MAX = max3(GREEN_MIN, YELLOW_LEN, CLEAR_LEN);
  localparam int CNT_W = $clog2(SPAN_MAX + 1);

  phase_t           phase_q, phase_n;
  logic [CNT_W-1:0] tmr_q, tmr_n, tick;
  logic [LANES-1:0] lit_q, lit_n;
  logic             axis_q, axis_n, last_q, last_n;
  logic [1:0]       pick;
  logic             min_ok, warn_done, clr_done, rival, hold, start;

  assign tick      = tmr_q + CNT_W'(1);
  assign pick      = choose_axis(dem_i, last_q);
  assign min_ok    = span_done(32'(tmr_q), GREEN_MIN);
  assign warn_done = span_done(32'(tmr_q), YELLOW_LEN);
  assign clr_done  = span_done(32'(tmr_q), CLEAR_LEN);
  assign rival     = |(dem_i & axis_mask(!axis_q));
  assign hold      = |(sens_i & lit_q);
  assign start     = (phase_q == PH_IDLE) || (phase_q == PH_CLEAR && clr_done);

  always_comb begin
    phase_n = phase_q;
    tmr_n   = tmr_q;
    lit_n   = lit_q;
    axis_n  = axis_q;
    last_n  = last_q;
    unique case (phase_q)
      PH_GO: begin
        if (min_ok && (rival || !hold)) begin
          phase_n = PH_WARN;
          tmr_n   = '0;
        end else begin
          lit_n = lit_q | (dem_i & axis_mask(axis_q));
          if (!min_ok) tmr_n = tick;
        end
      end
      PH_WARN: begin
        if (warn_done) begin
          phase_n = PH_CLEAR;
          tmr_n   = '0;
          lit_n   = '0;
        end else begin
          tmr_n = tick;
        end
      end
      PH_CLEAR: if (!clr_done) tmr_n = tick;
      default: ;
    endcase
    if (start) begin
      tmr_n = '0;
      if (pick[1]) begin
        phase_n = PH_GO;
        axis_n  = pick[0];
        last_n  = pick[0];
        lit_n   = dem_i & axis_mask(pick[0]);
      end else begin
        phase_n = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      lit_q   <= '0;
      axis_q  <= 1'b0;
      last_q  <= 1'b1;
    end else begin
      phase_q <= phase_n;
      tmr_q   <= tmr_n;
      lit_q   <= lit_n;
      axis_q  <= axis_n;
      last_q  <= last_n;
    end
  end

  assign phase_o = phase_q;
  assign lit_o   = lit_q;
endmodule

// File: rtl/tl_lamp_drive.sv
module tl_lamp_drive
  import tl_pkg::*;
(
  input  phase_t             phase_i,
  input  logic [LANES-1:0]   lit_i,
  output logic [2*LANES-1:0] lamps_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lamp_t st;
    always_comb begin
      st = LAMP_RED;
      if (lit_i[i] && phase_i == PH_GO)   st = LAMP_GRN;
      if (lit_i[i] && phase_i == PH_WARN) st = LAMP_YEL;
    end
    assign lamps_o[2*i +: 2] = st;
  end
endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned GREEN_MIN  = 8,
  parameter int unsigned YELLOW_LEN = 3,
  parameter int unsigned CLEAR_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] car_i,
  output logic [7:0] lamps_o
);
  logic [LANES-1:0] dem_w;
  logic [LANES-1:0] lit_w;
  logic [LANES-1:0] served_w;
  phase_t           phase_w;

  assign served_w = (phase_w == PH_GO) ? lit_w : '0;

  tl_demand_latch u_dem (
    .clk(clk), .rst(rst), .sens_i(car_i), .served_i(served_w), .dem_o(dem_w)
  );

  tl_phase_ctrl #(
    .GREEN_MIN(GREEN_MIN), .YELLOW_LEN(YELLOW_LEN), .CLEAR_LEN(CLEAR_LEN)
  ) u_ph (
    .clk(clk), .rst(rst), .dem_i(dem_w), .sens_i(car_i),
    .phase_o(phase_w), .lit_o(lit_w)
  );

  tl_lamp_drive u_lamp (
    .phase_i(phase_w), .lit_i(lit_w), .lamps_o(lamps_o)
  );
endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk #(
  parameter int unsigned GREEN_MIN  = 8,
  parameter int unsigned YELLOW_LEN = 3,
  parameter int unsigned CLEAR_LEN  = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] lamps_o,
  input logic [3:0] dem_w
);
  localparam int CW = $clog2(GREEN_MIN + YELLOW_LEN + CLEAR_LEN + 2) + 1;

  logic [3:0] g, y;
  for (genvar i = 0; i < 4; i++) begin : g_bits
    assign g[i] = (lamps_o[2*i +: 2] == 2'b10);
    assign y[i] = (lamps_o[2*i +: 2] == 2'b01);
  end

  logic any_g, any_y, all_red;
  assign any_g   = |g;
  assign any_y   = |y;
  assign all_red = (lamps_o == 8'h00);

  logic [CW-1:0] grun_q, yrun_q, rrun_q;
  logic          seen_y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grun_q <= '0; yrun_q <= '0; rrun_q <= '0; seen_y_q <= 1'b0;
    end else begin
      grun_q <= !any_g ? '0 : (grun_q < CW'(GREEN_MIN)) ? grun_q + CW'(1) : grun_q;
      yrun_q <= !any_y ? '0 : (yrun_q <= CW'(YELLOW_LEN)) ? yrun_q + CW'(1) : yrun_q;
      rrun_q <= !all_red ? '0 : (rrun_q < CW'(CLEAR_LEN)) ? rrun_q + CW'(1) : rrun_q;
      if (any_y) seen_y_q <= 1'b1;
      else if (any_g) seen_y_q <= 1'b0;
    end
  end

  a_r1_reset_red: assert property (@(posedge clk) rst |=> (lamps_o == 8'h00));

  a_r2_axis_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((|g[1:0]) && (|g[3:2])));

  a_r4_min_green: assert property (@(posedge clk) disable iff (rst)
    $fell(any_g) |-> (grun_q >= CW'(GREEN_MIN)));

  a_r5_yellow_len: assert property (@(posedge clk) disable iff (rst)
    $fell(any_y) |-> (yrun_q == CW'(YELLOW_LEN)));

  a_r6_clearance: assert property (@(posedge clk) disable iff (rst)
    $rose(any_g) |-> (!seen_y_q || rrun_q >= CW'(CLEAR_LEN)));

  for (genvar i = 0; i < 4; i++) begin : g_lane_chk
    a_r3_green_needs_demand: assert property (@(posedge clk) disable iff (rst)
      $rose(g[i]) |-> $past(dem_w[i]));
    a_r5_green_then_yellow: assert property (@(posedge clk) disable iff (rst)
      g[i] |=> (g[i] || y[i]));
    a_r5_no_red_to_yellow: assert property (@(posedge clk) disable iff (rst)
      (!g[i] && !y[i]) |=> !y[i]);
  end
endmodule

bind crossing_ctrl crossing_ctrl_chk #(
  .GREEN_MIN(GREEN_MIN), .YELLOW_LEN(YELLOW_LEN), .CLEAR_LEN(CLEAR_LEN)
) u_chk (
  .clk(clk), .rst(rst), .lamps_o(lamps_o), .dem_w(dem_w)
);

// File: tb/sim_crossing_ctrl.sv
`timescale 1ns/1ps
module sim_crossing_ctrl;
  localparam int G = 4, Y = 2, C = 2;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] car = 4'b0;
  logic [7:0] lamps;

  crossing_ctrl #(.GREEN_MIN(G), .YELLOW_LEN(Y), .CLEAR_LEN(C)) u0 (
    .clk(clk), .rst(rst), .car_i(car), .lamps_o(lamps)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int wait_bound();
    return 2*(G + Y + C) + 4;
  endfunction

  function automatic logic [1:0] lamp_at(input logic [7:0] v, input int i);
    return v[2*i +: 2];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  logic [7:0] prev = 8'h00;
  bit   [3:0] waiting = '0;
  int         age [4] = '{0, 0, 0, 0};
  int         yrun[4] = '{0, 0, 0, 0};
  int         grun = 0, gap = 0;
  bit         seen_y = 0;

  task automatic monitor();
    bit ag, pag, ay, ared;
    ag = 0; pag = 0; ay = 0;
    for (int i = 0; i < 4; i++) begin
      if (lamp_at(lamps, i) == 2'b10) ag = 1;
      if (lamp_at(prev, i) == 2'b10) pag = 1;
      if (lamp_at(lamps, i) == 2'b01) ay = 1;
    end
    ared = (lamps == 8'h00);
    // R2 axis exclusion
    chk(!((lamp_at(lamps,0)==2'b10 || lamp_at(lamps,1)==2'b10) &&
          (lamp_at(lamps,2)==2'b10 || lamp_at(lamps,3)==2'b10)),
        "R2 axis exclusion", lamps, 0);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] c, p;
      c = lamp_at(lamps, i);
      p = lamp_at(prev, i);
      if (car[i] && p != 2'b10) waiting[i] = 1;
      if (c == 2'b10 && p != 2'b10) begin
        chk(waiting[i], "R3 green without demand", i, 1);
        chk(age[i] <= wait_bound(), "R8 wait bound", age[i], wait_bound());
      end
      if (c == 2'b10) begin
        waiting[i] = 0; age[i] = 0;
      end else if (waiting[i]) begin
        age[i]++;
        if (age[i] == wait_bound() + 1) chk(0, "R8 starved lane", age[i], wait_bound());
      end
      if (p == 2'b10 && c != 2'b10) chk(c == 2'b01, "R5 green must go yellow", c, 1);
      if (p == 2'b00 && c == 2'b01) chk(0, "R5 red to yellow", c, 0);
      if (c == 2'b01) yrun[i]++;
      else if (p == 2'b01) begin
        chk(yrun[i] == Y && c == 2'b00, "R5 yellow length", yrun[i], Y);
        yrun[i] = 0;
      end
    end
    if (ag) grun++;
    else if (pag) begin
      chk(grun >= G, "R4 min green", grun, G);
      grun = 0;
    end
    if (ag && !pag) begin
      if (seen_y) chk(gap >= C, "R6 clearance", gap, C);
      seen_y = 0;
    end
    if (ay) begin seen_y = 1; gap = 0; end
    else if (ared) gap++;
    prev = lamps;
  endtask

  task automatic step(input logic [3:0] nxt);
    @(negedge clk);
    monitor();
    car = nxt;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(lamps == 8'h00, "R1 reset all red", lamps, 0);
    rst = 1'b0;
    repeat (3) begin
      step(4'b0000);
      chk(lamps == 8'h00, "R1 idle after reset", lamps, 0);
    end
    // R7: idle hit on lane 0 gives green next cycle
    step(4'b0001);
    step(4'b0001);
    chk(lamp_at(lamps,0) == 2'b10, "R7 idle response", lamp_at(lamps,0), 2);
    chk(lamp_at(lamps,1) == 2'b00, "R3 lone lane stays red", lamp_at(lamps,1), 0);
    // R10: hold while detector high, no rival
    for (int k = 0; k < 3*G; k++) begin
      step(4'b0001);
      chk(lamp_at(lamps,0) == 2'b10, "R10 hold green", lamp_at(lamps,0), 2);
    end
    // R9: same-axis join
    step(4'b0011);
    step(4'b0011);
    chk(lamp_at(lamps,1) == 2'b10, "R9 join axis green", lamp_at(lamps,1), 2);
    repeat (G + Y + C + 4) step(4'b0000);
    chk(lamps == 8'h00, "R3 no demand all red", lamps, 0);
    // R12: single pulse gives exactly G green cycles
    step(4'b0100);
    cnt = 0;
    step(4'b0000);
    while (lamp_at(lamps,2) == 2'b10 && cnt < 100) begin
      cnt++;
      step(4'b0000);
    end
    chk(cnt == G, "R12 pulse green length", cnt, G);
    repeat (Y + C + 4) step(4'b0000);
    // R11: simultaneous demand from idle, axis 1 served last -> axis 0 first
    step(4'b0101);
    step(4'b0000);
    chk(lamp_at(lamps,0) == 2'b10, "R11 other axis first", lamp_at(lamps,0), 2);
    chk(lamp_at(lamps,2) == 2'b00, "R11 last axis waits", lamp_at(lamps,2), 0);
    cnt = 0;
    while (lamp_at(lamps,2) != 2'b10 && cnt < 100) begin
      cnt++;
      step(4'b0000);
    end
    chk(lamp_at(lamps,2) == 2'b10 && cnt <= wait_bound(), "R8 waiting axis served",
        cnt, wait_bound());
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] nx;
      nx = car;
      for (int i = 0; i < 4; i++) if ($urandom_range(0, 7) == 0) nx[i] = ~nx[i];
      step(nx);
    end
    repeat (wait_bound() + 4) step(4'b0000);
    chk(waiting == 4'b0000, "R8 all demand served", waiting, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule